// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block is the software-visible control and status register set of an ECC memory controller. A word-addressed 32-bit window holds nine registers: the enable register, the delay register, the fault status register, a video configuration register, two fault address registers, a test register and two event counters. The register index is the byte address shifted right by two. Only full-word accesses reach this window. The ECC datapath reports each detected error through a one-cycle strobe. The block records the error and drives a level interrupt that software acknowledges by writing the fault status register.

A parameter `VARIANT` (0, 1 or 2) selects one of three controller generations. The variant fixes the implementation code in enable bits 31:28, the write mask of the enable register, and the enable bits that a warm reset preserves. Only variant 0 also decodes a separate diagnostic window of four byte-wide entries, selected by `req_diag`.

There are two resets. The asynchronous cold reset `rst_n` loads every register with its default. The synchronous warm reset `warm_clr` does the same, except that it keeps selected enable-register fields. The interrupt is a two-state machine. `IRQ_IDLE` moves to `IRQ_ACTIVE` on transition RAISE, which is a qualifying fault capture. `IRQ_ACTIVE` returns to `IRQ_IDLE` on transition ACK, a write to the fault status register with no raise in the same cycle, or on transition WARM, a warm reset.

Top module: `memctl_csr`

## Requirements
- R1: After cold reset the register values are as follows. Index 0 (enable) reads `VARIANT<<28`, index 1 (delay) reads 0x00000020, and index 4 (fault address 0) reads 0x07C00000. Every other index reads 0, and `irq` is low.
- R2: A word write to index 0 stores the data masked as follows, so that bits 31:28 always hold the variant code. Variant 0 uses mask 0x00000103. Variants 1 and 2 use mask 0x00000BFF, ORed with `VARIANT<<28`.
- R3: A word write to index 1 stores the data with bit 31 forced to 0.
- R4: A word write to index 2 stores the full written value and drops `irq` one cycle later, unless a fault raise occurs in the same cycle.
- R5: Indices 4 and 5 ignore bus writes. Indices 3, 6, 7 and 8 each store the full 32-bit word written to them, independently of each other.
- R6: A main-window access whose `req_size` is not 2 (word; 0 is byte) has no effect on any register, and a read of this kind returns 0. Indices 9 to 15 read as 0.
- R7: `warm_clr` restores the R1 defaults, except in the enable register. On variant 0 the enable register keeps only bit 8. On variants 1 and 2 it keeps bits 31:24, 11 and 9:2.
- R8: A fault strobe with `flt_ce` or `flt_ue` set, while enable bit 0 is 1, overwrites the fault status register. The new value has bit 0 = CE, bit 3 = UE, bits 7:4 = double-word index and bits 15:8 = syndrome, with all other bits 0 apart from bit 16 (R9). The same strobe loads `flt_addr0` and `flt_addr1` into indices 4 and 5. If enable bit 0 is 0, the strobe has no effect.
- R9: A capture sets status bit 16 (multiple errors) if, in the status value before the capture, bit 0, bit 3 or bit 16 was set.
- R10: A captured UE always raises `irq`. A captured CE-only fault raises `irq` only when enable bit 1 is 1. A capture takes priority over a bus write to index 2 in the same cycle.
- R11: On variant 0, byte writes with `req_diag` set store `req_wdata[7:0]` in entry `req_addr[1:0]`, and byte reads return that entry zero-extended. Non-byte diagnostic accesses are ignored and read as 0. On variants 1 and 2, all diagnostic accesses read 0.
- R12: `rsp_valid` is high exactly one cycle after each read request, and `rsp_rdata` holds the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_clr | input | 1 | Synchronous warm reset, keeps selected enable fields |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_diag | input | 1 | Selects the diagnostic byte window |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| rsp_valid | output | 1 | Read response strobe |
| flt_valid | input | 1 | Fault report strobe |
| flt_ce | input | 1 | Correctable error flag |
| flt_ue | input | 1 | Uncorrectable error flag |
| flt_syndrome | input | 8 | Error syndrome |
| flt_dword | input | 4 | Double-word index within the block |
| flt_addr0 | input | 32 | Fault address word 0 |
| flt_addr1 | input | 32 | Fault address word 1 |
| irq | output | 1 | Fault interrupt, level |

## Verification
The bench builds three copies of the block side by side, with `VARIANT` set to 0, 1 and 2 and the default 6-bit address. All three receive the same stimulus. The 6-bit address covers all sixteen word indices, including the seven unmapped ones, so read and write sweeps over the whole window are exhaustive. Running the three variants together puts every variant-dependent mask, implementation code and warm-reset keep set under the same sweep. It also shows the diagnostic window present on one copy and absent on the other two.

// File: rtl/memctl_csr_pkg.sv
package memctl_csr_pkg;

    localparam int NUM_REGS = 9;
    localparam int DATA_W   = 32;

    localparam int IDX_ENA   = 0;
    localparam int IDX_DLY   = 1;
    localparam int IDX_FSTAT = 2;
    localparam int IDX_VID   = 3;
    localparam int IDX_FADR0 = 4;
    localparam int IDX_FADR1 = 5;
    localparam int IDX_TST   = 6;
    localparam int IDX_EVT0  = 7;
    localparam int IDX_EVT1  = 8;

    localparam logic [DATA_W-1:0] DLY_RST   = 32'h0000_0020;
    localparam logic [DATA_W-1:0] DLY_WMASK = 32'h7FFF_FFFF;
    localparam logic [DATA_W-1:0] FADR0_RST = 32'h07C0_0000;

    localparam int FS_CE = 0;
    localparam int FS_UE = 3;
    localparam int FS_ME = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;

    function automatic logic [DATA_W-1:0] impl_code(input int variant);
        return DATA_W'(variant) << 28;
    endfunction

    function automatic logic [DATA_W-1:0] ena_wmask(input int variant);
        return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
    endfunction

    function automatic logic [DATA_W-1:0] ena_keep(input int variant);
        return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
    endfunction

endpackage

// File: rtl/memctl_csr_decode.sv
module memctl_csr_decode
    import memctl_csr_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NREG     = NUM_REGS,
    parameter int DIAG_IDX = 2
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_diag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic [NREG-1:0]   wr_sel,
    output logic              main_rd,
    output logic [ADDR_W-3:0] rd_idx,
    output logic              diag_wr,
    output logic              diag_rd,
    output logic [DIAG_IDX-1:0] diag_idx
);
    localparam int IDX_W = ADDR_W - 2;

    logic             main_ok;
    logic             diag_ok;
    logic [IDX_W-1:0] word_idx;

    always_comb begin
        word_idx = req_addr[ADDR_W-1:2];
        main_ok  = req_valid && !req_diag && (req_size == SZ_WORD);
        diag_ok  = req_valid &&  req_diag && (req_size == SZ_BYTE);
        main_rd  = main_ok && !req_write;
        rd_idx   = word_idx;
        diag_wr  = diag_ok &&  req_write;
        diag_rd  = diag_ok && !req_write;
        diag_idx = req_addr[DIAG_IDX-1:0];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_wsel
        assign wr_sel[g] = main_ok && req_write && (word_idx == IDX_W'(g));
    end

endmodule

// File: rtl/memctl_csr_irq_fsm.sv
module memctl_csr_irq_fsm
    import memctl_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic warm_clr,
    input  logic raise,
    input  logic ack,
    output logic irq
);
    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (!warm_clr && raise) state_d = IRQ_ACTIVE;
            end
            IRQ_ACTIVE: begin
                if (warm_clr)           state_d = IRQ_IDLE;
                else if (!raise && ack) state_d = IRQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_ACTIVE);
    end

endmodule

// File: rtl/memctl_csr_diag.sv
module memctl_csr_diag #(
    parameter int DEPTH = 4,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] cell_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              cell_q[e] <= '0;
            else if (wr_en && (idx == IDX_W'(e)))    cell_q[e] <= wdata;
        end
    end

    always_comb rdata = cell_q[idx];

endmodule

// File: rtl/memctl_csr.sv
module memctl_csr
    import memctl_csr_pkg::*;
#(
    parameter int VARIANT = 0,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_clr,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_diag,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_valid,
    input  logic              flt_valid,
    input  logic              flt_ce,
    input  logic              flt_ue,
    input  logic [7:0]        flt_syndrome,
    input  logic [3:0]        flt_dword,
    input  logic [31:0]       flt_addr0,
    input  logic [31:0]       flt_addr1,
    output logic              irq
);
    localparam logic [DATA_W-1:0] IMPL  = impl_code(VARIANT);
    localparam logic [DATA_W-1:0] WMASK = ena_wmask(VARIANT);
    localparam logic [DATA_W-1:0] KEEP  = ena_keep(VARIANT);
    localparam int DIAG_DEPTH = 4;
    localparam int DIAG_IW    = $clog2(DIAG_DEPTH);

    logic [NUM_REGS-1:0] wr_sel;
    logic                main_rd;
    logic [ADDR_W-3:0]   rd_idx;
    logic                diag_wr;
    logic                diag_rd;
    logic [DIAG_IW-1:0]  diag_idx;
    logic [7:0]          diag_rbyte;

    logic [DATA_W-1:0] ena_q, dly_q, fstat_q, vid_q;
    logic [DATA_W-1:0] fadr0_q, fadr1_q, tst_q, evt0_q, evt1_q;

    logic              fault_cap;
    logic              prior_err;
    logic              raise;
    logic [DATA_W-1:0] fstat_cap;
    logic [DATA_W-1:0] rd_word;

    memctl_csr_decode #(
        .ADDR_W  (ADDR_W),
        .NREG    (NUM_REGS),
        .DIAG_IDX(DIAG_IW)
    ) u_decode (
        .req_valid(req_valid),
        .req_write(req_write),
        .req_diag (req_diag),
        .req_addr (req_addr),
        .req_size (req_size),
        .wr_sel   (wr_sel),
        .main_rd  (main_rd),
        .rd_idx   (rd_idx),
        .diag_wr  (diag_wr),
        .diag_rd  (diag_rd),
        .diag_idx (diag_idx)
    );

    // fault capture: new status word and interrupt qualification
    always_comb begin
        fault_cap = flt_valid && ena_q[0] && (flt_ce || flt_ue) && !warm_clr;
        prior_err = fstat_q[FS_CE] || fstat_q[FS_UE] || fstat_q[FS_ME];
        fstat_cap = {15'd0, prior_err, flt_syndrome, flt_dword, flt_ue, 2'b00, flt_ce};
        raise     = fault_cap && (flt_ue || (flt_ce && ena_q[1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ena_q   <= IMPL;
            dly_q   <= DLY_RST;
            fstat_q <= '0;
            vid_q   <= '0;
            fadr0_q <= FADR0_RST;
            fadr1_q <= '0;
            tst_q   <= '0;
            evt0_q  <= '0;
            evt1_q  <= '0;
        end else if (warm_clr) begin
            ena_q   <= (ena_q & KEEP) | IMPL;
            dly_q   <= DLY_RST;
            fstat_q <= '0;
            vid_q   <= '0;
            fadr0_q <= FADR0_RST;
            fadr1_q <= '0;
            tst_q   <= '0;
            evt0_q  <= '0;
            evt1_q  <= '0;
        end else begin
            if (wr_sel[IDX_ENA]) ena_q  <= (req_wdata & WMASK) | IMPL;
            if (wr_sel[IDX_DLY]) dly_q  <= req_wdata & DLY_WMASK;
            if (wr_sel[IDX_VID]) vid_q  <= req_wdata;
            if (wr_sel[IDX_TST]) tst_q  <= req_wdata;
            if (wr_sel[IDX_EVT0]) evt0_q <= req_wdata;
            if (wr_sel[IDX_EVT1]) evt1_q <= req_wdata;
            if (fault_cap) begin
                fstat_q <= fstat_cap;
                fadr0_q <= flt_addr0;
                fadr1_q <= flt_addr1;
            end else if (wr_sel[IDX_FSTAT]) begin
                fstat_q <= req_wdata;
            end
        end
    end

    memctl_csr_irq_fsm u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_clr(warm_clr),
        .raise   (raise),
        .ack     (wr_sel[IDX_FSTAT]),
        .irq     (irq)
    );

    if (VARIANT == 0) begin : g_diag
        memctl_csr_diag #(
            .DEPTH (DIAG_DEPTH),
            .IDX_W (DIAG_IW),
            .BYTE_W(8)
        ) u_diag (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_en(diag_wr),
            .idx  (diag_idx),
            .wdata(req_wdata[7:0]),
            .rdata(diag_rbyte)
        );
    end else begin : g_no_diag
        assign diag_rbyte = 8'h00;
    end

    always_comb begin
        case (32'(rd_idx))
            IDX_ENA:   rd_word = ena_q;
            IDX_DLY:   rd_word = dly_q;
            IDX_FSTAT: rd_word = fstat_q;
            IDX_VID:   rd_word = vid_q;
            IDX_FADR0: rd_word = fadr0_q;
            IDX_FADR1: rd_word = fadr1_q;
            IDX_TST:   rd_word = tst_q;
            IDX_EVT0:  rd_word = evt0_q;
            IDX_EVT1:  rd_word = evt1_q;
            default:   rd_word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid && !req_write;
            if (main_rd)      rsp_rdata <= rd_word;
            else if (diag_rd) rsp_rdata <= {24'd0, diag_rbyte};
            else              rsp_rdata <= '0;
        end
    end

endmodule

// File: rtl/memctl_csr_chk.sv
module memctl_csr_chk
    import memctl_csr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                warm_clr,
    input logic                req_valid,
    input logic                req_write,
    input logic                req_diag,
    input logic [1:0]          req_size,
    input logic [NUM_REGS-1:0] wr_sel,
    input logic                flt_valid,
    input logic                flt_ce,
    input logic                flt_ue,
    input logic [31:0]         ena_q,
    input logic [31:0]         fstat_q,
    input logic [31:0]         fadr0_q,
    input logic [31:0]         vid_q,
    input logic                rsp_valid,
    input logic                irq
);
    AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[IDX_FSTAT] && !flt_valid && !warm_clr |=> !irq); // R4

    AST_FADR_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[IDX_FADR0] && !flt_valid && !warm_clr |=> $stable(fadr0_q)); // R5

    AST_NONWORD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_write && !req_diag && (req_size != 2'd2) && !warm_clr |=> $stable(vid_q)); // R6

    AST_FLT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !ena_q[0] && !wr_sel[IDX_FSTAT] && !warm_clr |=> $stable(fstat_q)); // R8

    AST_UE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && flt_ue && ena_q[0] && !warm_clr |=> irq); // R10

    AST_CE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && flt_ce && !flt_ue && !ena_q[1] && !wr_sel[IDX_FSTAT] && !warm_clr
        |=> irq == $past(irq)); // R10

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_write |=> rsp_valid); // R12

    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R12

endmodule

bind memctl_csr memctl_csr_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .warm_clr (warm_clr),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_diag (req_diag),
    .req_size (req_size),
    .wr_sel   (wr_sel),
    .flt_valid(flt_valid),
    .flt_ce   (flt_ce),
    .flt_ue   (flt_ue),
    .ena_q    (ena_q),
    .fstat_q  (fstat_q),
    .fadr0_q  (fadr0_q),
    .vid_q    (vid_q),
    .rsp_valid(rsp_valid),
    .irq      (irq)
);

// File: tb/memctl_csr_tb.sv
module memctl_csr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_clr = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_diag = 1'b0;
    logic [5:0]  req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [31:0] req_wdata = '0;
    logic        flt_valid = 1'b0;
    logic        flt_ce = 1'b0;
    logic        flt_ue = 1'b0;
    logic [7:0]  flt_syndrome = '0;
    logic [3:0]  flt_dword = '0;
    logic [31:0] flt_addr0 = '0;
    logic [31:0] flt_addr1 = '0;

    logic [31:0] rdata_w [NV];
    logic        rvalid_w [NV];
    logic        irq_w [NV];
    logic [31:0] got [NV];

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    for (genvar gv = 0; gv < NV; gv++) begin : g_var
        memctl_csr #(.VARIANT(gv), .ADDR_W(6)) dut_i (
            .clk(clk), .rst_n(rst_n), .warm_clr(warm_clr),
            .req_valid(req_valid), .req_write(req_write), .req_diag(req_diag),
            .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
            .rsp_rdata(rdata_w[gv]), .rsp_valid(rvalid_w[gv]),
            .flt_valid(flt_valid), .flt_ce(flt_ce), .flt_ue(flt_ue),
            .flt_syndrome(flt_syndrome), .flt_dword(flt_dword),
            .flt_addr0(flt_addr0), .flt_addr1(flt_addr1),
            .irq(irq_w[gv])
        );
    end

    task automatic chk(input string tag, input int v, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s variant=%0d act=%h exp=%h", tag, v, act, exp);
        end
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [1:0] sz, input logic dg, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_diag = dg; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_diag = 1'b0; req_size = 2'd2;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [1:0] sz, input logic dg);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_diag = dg;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            got[v] = rdata_w[v];
            chk("R12 rsp_valid", v, {31'd0, rvalid_w[v]}, 32'd1);
        end
        req_valid = 1'b0; req_diag = 1'b0; req_size = 2'd2;
    endtask

    task automatic fault(input logic ce, input logic ue, input logic [7:0] syn, input logic [3:0] dw,
                         input logic [31:0] a0, input logic [31:0] a1, input logic with_ack);
        @(negedge clk);
        flt_valid = 1'b1; flt_ce = ce; flt_ue = ue; flt_syndrome = syn; flt_dword = dw;
        flt_addr0 = a0; flt_addr1 = a1;
        if (with_ack) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(2 << 2); req_size = 2'd2; req_wdata = 32'h0;
        end
        @(negedge clk);
        flt_valid = 1'b0; flt_ce = 1'b0; flt_ue = 1'b0;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    function automatic logic [31:0] exp_rst(input int v, input int idx);
        case (idx)
            0: return 32'(v) << 28;
            1: return 32'h20;
            4: return 32'h07C0_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_wr(input int v, input int idx, input logic [31:0] d);
        case (idx)
            0: return (v == 0) ? (d & 32'h103) : ((32'(v) << 28) | (d & 32'hBFF));
            1: return d & 32'h7FFF_FFFF;
            2, 3, 6, 7, 8: return d;
            4: return 32'h07C0_0000;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] pat(input int idx);
        return 32'h5AC3_1E96 ^ (32'(idx) * 32'h0101_0101);
    endfunction

    task automatic read_all_ena(input logic [31:0] d, input string tag);
        bus_read(6'd0, 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk(tag, v, got[v], exp_wr(v, 0, d));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R12 act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: cold reset state, R6: unmapped indices read zero
        for (int v = 0; v < NV; v++) chk("R1 irq", v, {31'd0, irq_w[v]}, 32'd0);
        for (int i = 0; i < 16; i++) begin
            bus_read(6'(i << 2), 2'd2, 1'b0);
            for (int v = 0; v < NV; v++) chk(i > 8 ? "R6 unmapped" : "R1 reset", v, got[v], exp_rst(v, i));
        end

        // R2 R3 R4 R5: sweep with all-ones
        for (int i = 0; i < 16; i++) bus_write(6'(i << 2), 2'd2, 1'b0, 32'hFFFF_FFFF);
        for (int i = 0; i < 16; i++) begin
            bus_read(6'(i << 2), 2'd2, 1'b0);
            for (int v = 0; v < NV; v++) chk("R2 R3 R4 R5 ones", v, got[v], exp_wr(v, i, 32'hFFFF_FFFF));
        end

        // R7: warm reset keeps selected enable bits
        @(negedge clk); warm_clr = 1'b1;
        @(negedge clk); warm_clr = 1'b0;
        for (int i = 0; i < 16; i++) begin
            bus_read(6'(i << 2), 2'd2, 1'b0);
            for (int v = 0; v < NV; v++) begin
                if (i == 0) chk("R7 enable kept", v, got[v], (v == 0) ? 32'h100 : ((32'(v) << 28) | 32'hBFC));
                else        chk("R7 defaults", v, got[v], exp_rst(v, i));
            end
        end

        // R5 independence: distinct pattern per index, write then read each
        for (int i = 0; i < 16; i++) begin
            bus_write(6'(i << 2), 2'd2, 1'b0, pat(i));
            bus_read(6'(i << 2), 2'd2, 1'b0);
            for (int v = 0; v < NV; v++) chk("R5 pattern", v, got[v], exp_wr(v, i, pat(i)));
        end
        for (int i = 6; i < 9; i++) begin
            bus_read(6'(i << 2), 2'd2, 1'b0);
            for (int v = 0; v < NV; v++) chk("R5 counters independent", v, got[v], pat(i));
        end

        // R6: non-word accesses
        bus_write(6'(3 << 2), 2'd0, 1'b0, 32'hDEAD_BEEF);
        bus_write(6'(3 << 2), 2'd1, 1'b0, 32'hDEAD_BEEF);
        bus_read(6'(3 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R6 nonword write", v, got[v], pat(3));
        bus_read(6'(1 << 2), 2'd0, 1'b0);
        for (int v = 0; v < NV; v++) chk("R6 nonword read", v, got[v], 32'h0);

        // R8 R10: CE capture with interrupt disabled
        bus_write(6'd0, 2'd2, 1'b0, 32'h1);
        bus_write(6'(2 << 2), 2'd2, 1'b0, 32'h0);
        fault(1'b1, 1'b0, 8'h5A, 4'h3, 32'hCAFE_0001, 32'hBEEF_0002, 1'b0);
        for (int v = 0; v < NV; v++) chk("R10 ce no irq", v, {31'd0, irq_w[v]}, 32'd0);
        bus_read(6'(2 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R8 status layout", v, got[v], 32'h0000_5A31);
        bus_read(6'(4 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R8 addr0", v, got[v], 32'hCAFE_0001);
        bus_read(6'(5 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R8 addr1", v, got[v], 32'hBEEF_0002);

        // R9 R10: UE on top of CE sets ME and raises irq
        fault(1'b0, 1'b1, 8'h00, 4'hC, 32'h1111_0000, 32'h2222_0000, 1'b0);
        for (int v = 0; v < NV; v++) chk("R10 ue irq", v, {31'd0, irq_w[v]}, 32'd1);
        bus_read(6'(2 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R9 multiple", v, got[v], 32'h0001_00C8);

        // R4: acknowledge
        bus_write(6'(2 << 2), 2'd2, 1'b0, 32'h0);
        for (int v = 0; v < NV; v++) chk("R4 irq cleared", v, {31'd0, irq_w[v]}, 32'd0);

        // R8: fault ignored with enable bit 0 clear
        bus_write(6'd0, 2'd2, 1'b0, 32'h0);
        fault(1'b1, 1'b1, 8'hFF, 4'hF, 32'h3333_3333, 32'h4444_4444, 1'b0);
        for (int v = 0; v < NV; v++) chk("R8 disabled irq", v, {31'd0, irq_w[v]}, 32'd0);
        bus_read(6'(2 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R8 disabled status", v, got[v], 32'h0);
        bus_read(6'(4 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R8 disabled addr0", v, got[v], 32'h1111_0000);

        // R10: CE with interrupt enable
        bus_write(6'd0, 2'd2, 1'b0, 32'h3);
        read_all_ena(32'h3, "R2 enable 3");
        fault(1'b1, 1'b0, 8'h81, 4'h1, 32'h5, 32'h6, 1'b0);
        for (int v = 0; v < NV; v++) chk("R10 ce irq", v, {31'd0, irq_w[v]}, 32'd1);
        bus_read(6'(2 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R8 ce status", v, got[v], 32'h0000_8111);

        // R10: capture wins over simultaneous status write
        fault(1'b0, 1'b1, 8'h3C, 4'h2, 32'h7, 32'h8, 1'b1);
        for (int v = 0; v < NV; v++) chk("R10 collide irq", v, {31'd0, irq_w[v]}, 32'd1);
        bus_read(6'(2 << 2), 2'd2, 1'b0);
        for (int v = 0; v < NV; v++) chk("R10 collide status", v, got[v], 32'h0001_3C28);
        bus_write(6'(2 << 2), 2'd2, 1'b0, 32'h0);
        for (int v = 0; v < NV; v++) chk("R4 irq cleared again", v, {31'd0, irq_w[v]}, 32'd0);

        // R11: diagnostic byte window
        for (int i = 0; i < 4; i++) bus_write(6'(i), 2'd0, 1'b1, 32'hFFFF_FFA0 + 32'(i));
        bus_write(6'd1, 2'd2, 1'b1, 32'h77);
        bus_write(6'd6, 2'd0, 1'b1, 32'h5C);
        for (int i = 0; i < 4; i++) begin
            bus_read(6'(i), 2'd0, 1'b1);
            for (int v = 0; v < NV; v++)
                chk("R11 diag byte", v, got[v], (v != 0) ? 32'h0 : ((i == 2) ? 32'h5C : 32'hA0 + 32'(i)));
        end
        bus_read(6'd0, 2'd2, 1'b1);
        for (int v = 0; v < NV; v++) chk("R11 diag word read", v, got[v], 32'h0);
        read_all_ena(32'h3, "R11 enable untouched");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule